// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 interrupt sources into two 32-bit banks and folds them into one interrupt request line for a processor. Sources 0 to 31 form the low bank and sources 32 to 63 form the high bank. Each source has a one-bit raise input and a one-bit cancel input. A raise marks the source pending. A cancel withdraws it.

Software reaches the block through a small register bus with byte offsets. Through this bus it sets a per-bank enable mask, reads the pending bits of each bank and acknowledges pending bits by writing ones. The low bank also has a level-status register. A low-bank source whose bit is set in the constant `LEVEL_MASK` parameter sets its level bit when raised. Only a cancel of that source clears the level bit. An acknowledge leaves it alone. The level bits take part in the request together with the low pending bits. So an acknowledged level source keeps the request up until the source itself is cancelled.

The block has no state machine. All state is held in plain registers that each bank updates every clock. The request line is a combinational function of these registers. Read data and the error strobe each pass through one register.

Top module: `irq_bank_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when ((low pending OR low level) AND low enable) is nonzero or (high pending AND high enable) is nonzero.
- R2: Offset 0x24 holds the low-bank enable mask and offset 0x14 holds the high-bank enable mask. A write sets the whole mask and a read returns it.
- R3: A write to 0x28 clears every low pending bit whose data bit is 1, and a write to 0x18 does the same for the high bank. Neither write changes the level register.
- R4: A read of 0x20 returns the low pending bits, a read of 0x10 returns the high pending bits and a read of 0x2c returns the low level register.
- R5: Reads of 0x1c and 0x38 return zero without an error. A write to 0x38 changes nothing and raises no error.
- R6: Raise input bit n sets pending bit n mod 32 in the high bank when n > 31 and in the low bank otherwise. When n < 32 and bit n of `LEVEL_MASK` is 1, it also sets level bit n.
- R7: Cancel input bit n clears that source's pending bit and, for the low bank, its level bit. Cancel takes priority over a raise of the same source in the same cycle.
- R8: Reset clears both pending registers, both enable registers and the level register, so `irq_o`, `rd_data_o` and `err_o` are 0 after reset.
- R9: Raise, cancel and register writes take effect at the clock edge that samples them. `irq_o` follows from the registers, so it does not respond to a raise before that edge. `rd_data_o` is valid in the cycle after `rd_en_i`.
- R10: Any access to an offset not mapped for that direction reads zero and changes nothing. Such offsets include writes to 0x10, 0x1c, 0x20 and 0x2c, and reads of 0x18 and 0x28. `err_o` is 1 for exactly the cycle after such an access and 0 after a mapped access.
- R11: When a raise and an acknowledge hit the same pending bit in the same cycle, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| raise_i | input | 64 | Per-source raise, bit n for source n |
| cancel_i | input | 64 | Per-source cancel, bit n for source n |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| err_o | output | 1 | One-cycle strobe for an unmapped access |

## Verification
The bench walks every one of the 64 sources through the sequence raise, enable, acknowledge and cancel. At each step it checks the request line and the register reads against a model of the bank and bit index. This sequence catches several faults: a design that mixed up the banks or the n mod 32 index, one that let an acknowledge clear level bits, and one that marked high-bank sources as level. Each of these would leave the request line or a read value wrong.

Separate cases cover the same-cycle collisions. A raise together with an acknowledge must leave the bit pending. A raise together with a cancel must leave it clear. A wrong priority would drop a live interrupt or keep a dead one.

The unmapped-access cases check three things: writes to read-only offsets must not alter state, reads of the acknowledge offsets must read zero, and 0x1c and 0x38 must not raise the error strobe. A decode that was too loose or too strict shows up as wrong data or a wrong `err_o`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // register selection produced by the address decoder
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_ACK_LO,
        SEL_ACK_HI,
        SEL_PEND_LO,
        SEL_PEND_HI,
        SEL_LVL_LO,
        SEL_ZERO
    } reg_sel_e;

    // byte offsets of the register window
    localparam int OFF_PEND_HI = 'h10;
    localparam int OFF_EN_HI   = 'h14;
    localparam int OFF_ACK_HI  = 'h18;
    localparam int OFF_SPARE   = 'h1c;
    localparam int OFF_PEND_LO = 'h20;
    localparam int OFF_EN_LO   = 'h24;
    localparam int OFF_ACK_LO  = 'h28;
    localparam int OFF_LVL_LO  = 'h2c;
    localparam int OFF_TONE    = 'h38;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output reg_sel_e          wsel_o,
    output reg_sel_e          rsel_o,
    output logic              bad_o
);

    // write-side map
    always_comb begin
        wsel_o = SEL_NONE;
        if (wr_en_i) begin
            case (addr_i)
                ADDR_W'(OFF_EN_LO):  wsel_o = SEL_EN_LO;
                ADDR_W'(OFF_EN_HI):  wsel_o = SEL_EN_HI;
                ADDR_W'(OFF_ACK_LO): wsel_o = SEL_ACK_LO;
                ADDR_W'(OFF_ACK_HI): wsel_o = SEL_ACK_HI;
                ADDR_W'(OFF_TONE):   wsel_o = SEL_ZERO;
                default:             wsel_o = SEL_NONE;
            endcase
        end
    end

    // read-side map
    always_comb begin
        rsel_o = SEL_NONE;
        if (rd_en_i) begin
            case (addr_i)
                ADDR_W'(OFF_EN_LO):   rsel_o = SEL_EN_LO;
                ADDR_W'(OFF_EN_HI):   rsel_o = SEL_EN_HI;
                ADDR_W'(OFF_PEND_LO): rsel_o = SEL_PEND_LO;
                ADDR_W'(OFF_PEND_HI): rsel_o = SEL_PEND_HI;
                ADDR_W'(OFF_LVL_LO):  rsel_o = SEL_LVL_LO;
                ADDR_W'(OFF_SPARE),
                ADDR_W'(OFF_TONE):    rsel_o = SEL_ZERO;
                default:              rsel_o = SEL_NONE;
            endcase
        end
    end

    assign bad_o = (wr_en_i && (wsel_o == SEL_NONE)) ||
                   (rd_en_i && (rsel_o == SEL_NONE));

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int             W         = 32,
    parameter bit             HAS_LEVEL = 1'b0,
    parameter logic [W-1:0]   LVL_MASK  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raise_i,
    input  logic [W-1:0] cancel_i,
    input  logic         en_we_i,
    input  logic         ack_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] en_o,
    output logic         req_o
);

    logic [W-1:0] pend_q;
    logic [W-1:0] en_q;
    logic [W-1:0] ack_bits;

    assign ack_bits = ack_we_i ? wdata_i : '0;

    // raise beats acknowledge, cancel beats raise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~ack_bits) | raise_i) & ~cancel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_i) begin
            en_q <= wdata_i;
        end
    end

    generate
        if (HAS_LEVEL) begin : g_level
            logic [W-1:0] lvl_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else begin
                    lvl_q <= (lvl_q | (raise_i & LVL_MASK)) & ~cancel_i;
                end
            end
            assign lvl_o = lvl_q;
        end else begin : g_no_level
            assign lvl_o = '0;
        end
    endgenerate

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign req_o  = |((pend_q | lvl_o) & en_q);

    // R6
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raise_i & ~cancel_i)) |=> ((pend_q & $past(raise_i & ~cancel_i)) == $past(raise_i & ~cancel_i)));

    // R7
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cancel_i) |=> (((pend_q | lvl_o) & $past(cancel_i)) == '0));

    // R3
    ack_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we_i && (raise_i == '0) && (cancel_i == '0)) |=> $stable(lvl_o));

    // R6
    level_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o & ~LVL_MASK) == '0);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int           BANK_W     = 32,
    parameter int           ADDR_W     = 8,
    parameter logic [31:0]  LEVEL_MASK = 32'h0010_0C00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BANK_W-1:0] raise_i,
    input  logic [2*BANK_W-1:0] cancel_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [BANK_W-1:0]   wr_data_i,
    input  logic                rd_en_i,
    output logic [BANK_W-1:0]   rd_data_o,
    output logic                irq_o,
    output logic                err_o
);

    localparam int NSRC = 2 * BANK_W;

    reg_sel_e           wsel;
    reg_sel_e           rsel;
    logic               bad;
    logic [BANK_W-1:0]  pend_lo, pend_hi, lvl_lo, lvl_hi, en_lo, en_hi;
    logic               req_lo, req_hi;
    logic [BANK_W-1:0]  rd_mux;
    logic [BANK_W-1:0]  rd_q;
    logic               err_q;

    irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .wsel_o  (wsel),
        .rsel_o  (rsel),
        .bad_o   (bad)
    );

    irqc_bank #(.W(BANK_W), .HAS_LEVEL(1'b1), .LVL_MASK(LEVEL_MASK[BANK_W-1:0])) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (raise_i[BANK_W-1:0]),
        .cancel_i (cancel_i[BANK_W-1:0]),
        .en_we_i  (wsel == SEL_EN_LO),
        .ack_we_i (wsel == SEL_ACK_LO),
        .wdata_i  (wr_data_i),
        .pend_o   (pend_lo),
        .lvl_o    (lvl_lo),
        .en_o     (en_lo),
        .req_o    (req_lo)
    );

    irqc_bank #(.W(BANK_W), .HAS_LEVEL(1'b0), .LVL_MASK('0)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (raise_i[NSRC-1:BANK_W]),
        .cancel_i (cancel_i[NSRC-1:BANK_W]),
        .en_we_i  (wsel == SEL_EN_HI),
        .ack_we_i (wsel == SEL_ACK_HI),
        .wdata_i  (wr_data_i),
        .pend_o   (pend_hi),
        .lvl_o    (lvl_hi),
        .en_o     (en_hi),
        .req_o    (req_hi)
    );

    always_comb begin
        case (rsel)
            SEL_EN_LO:   rd_mux = en_lo;
            SEL_EN_HI:   rd_mux = en_hi;
            SEL_PEND_LO: rd_mux = pend_lo;
            SEL_PEND_HI: rd_mux = pend_hi;
            SEL_LVL_LO:  rd_mux = lvl_lo;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            rd_q  <= rd_mux;
            err_q <= bad;
        end
    end

    assign rd_data_o = rd_q;
    assign err_o     = err_q;
    assign irq_o     = req_lo | req_hi;

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_o && !err_o && (rd_data_o == '0)));

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !rd_en_i) |=> !err_o);

    // R10
    no_read_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));

    // R1
    high_bank_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_hi == '0);

endmodule

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;

    localparam logic [31:0] LVL = 32'h0010_0C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] raise = '0;
    logic [63:0] cancel = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic        err;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_bank_ctrl #(.BANK_W(32), .ADDR_W(8), .LEVEL_MASK(LVL)) dut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise), .cancel_i(cancel),
        .addr_i(addr), .wr_en_i(wr), .wr_data_i(wdata), .rd_en_i(rd),
        .rd_data_o(rdata), .irq_o(irq), .err_o(err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata; e = err;
    endtask

    task automatic pulse(input int n, input bit is_cancel);
        @(negedge clk);
        if (is_cancel) cancel[n] = 1'b1; else raise[n] = 1'b1;
        @(negedge clk);
        raise = '0; cancel = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 irq", irq, 0);
        chk("R8 err", err, 0);
        chk("R8 rdata", rdata, 0);
        bus_rd(8'h20, d, e); chk("R8 pend_lo", d, 0);
        bus_rd(8'h10, d, e); chk("R8 pend_hi", d, 0);
        bus_rd(8'h24, d, e); chk("R8 en_lo", d, 0);
        bus_rd(8'h14, d, e); chk("R8 en_hi", d, 0);
        bus_rd(8'h2c, d, e); chk("R8 lvl", d, 0);

        // sweep every source through raise, enable, ack, cancel
        for (int n = 0; n < 64; n++) begin
            int          idx;
            bit          hi;
            bit          islvl;
            logic [31:0] b;
            idx   = n % 32;
            hi    = (n > 31);
            islvl = !hi && LVL[idx];
            b     = 32'h1 << idx;
            pulse(n, 1'b0);
            bus_rd(hi ? 8'h10 : 8'h20, d, e); chk("R6 pending bit", d, b);
            chk("R4 err on pending read", e, 0);
            bus_rd(hi ? 8'h20 : 8'h10, d, e); chk("R6 other bank clear", d, 0);
            bus_rd(8'h2c, d, e); chk("R6 level bit", d, islvl ? b : 32'h0);
            chk("R1 irq masked", irq, 0);
            bus_wr(hi ? 8'h14 : 8'h24, b);
            chk("R1 irq enabled", irq, 1);
            bus_rd(hi ? 8'h14 : 8'h24, d, e); chk("R2 enable readback", d, b);
            bus_wr(hi ? 8'h18 : 8'h28, b);
            chk("R3 irq after ack", irq, islvl);
            bus_rd(8'h2c, d, e); chk("R3 level kept by ack", d, islvl ? b : 32'h0);
            pulse(n, 1'b1);
            chk("R7 irq after cancel", irq, 0);
            bus_rd(8'h2c, d, e); chk("R7 level cleared", d, 0);
            bus_rd(hi ? 8'h10 : 8'h20, d, e); chk("R7 pending cleared", d, 0);
            bus_wr(hi ? 8'h14 : 8'h24, 32'h0);
        end

        // R9 multi-source pattern and edge timing
        bus_wr(8'h14, 32'h0000_0100);
        @(negedge clk);
        raise = 64'h5A5A_0100_0000_00F3;
        #1 chk("R9 irq not before edge", irq, 0);
        @(negedge clk);
        raise = '0;
        chk("R9 irq after edge", irq, 1);
        bus_rd(8'h20, d, e); chk("R6 pattern low", d, 32'h0000_00F3);
        bus_rd(8'h10, d, e); chk("R6 pattern high", d, 32'h5A5A_0100);
        chk("R9 rdata held", rdata, 32'h5A5A_0100);
        bus_wr(8'h18, 32'h0000_0100);
        chk("R1 irq after high ack", irq, 0);
        bus_rd(8'h10, d, e); chk("R3 partial ack", d, 32'h5A5A_0000);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h28, 32'hFFFF_FFFF);
        bus_wr(8'h14, 32'h0);

        // R11 raise and ack together
        @(negedge clk);
        raise[40] = 1'b1; addr = 8'h18; wdata = 32'h0000_0100; wr = 1'b1;
        @(negedge clk);
        raise = '0; wr = 1'b0;
        bus_rd(8'h10, d, e); chk("R11 raise beats ack", d, 32'h0000_0100);
        bus_wr(8'h18, 32'h0000_0100);
        bus_rd(8'h10, d, e); chk("R3 later ack clears", d, 0);

        // R7 raise and cancel together
        @(negedge clk);
        raise[10] = 1'b1; cancel[10] = 1'b1;
        @(negedge clk);
        raise = '0; cancel = '0;
        bus_rd(8'h20, d, e); chk("R7 cancel beats raise pending", d, 0);
        bus_rd(8'h2c, d, e); chk("R7 cancel beats raise level", d, 0);

        // R5 fixed-zero offsets
        pulse(3, 1'b0);
        bus_rd(8'h1c, d, e); chk("R5 read 1c data", d, 0); chk("R5 read 1c err", e, 0);
        bus_rd(8'h38, d, e); chk("R5 read 38 data", d, 0); chk("R5 read 38 err", e, 0);
        bus_wr(8'h38, 32'hFFFF_FFFF);
        chk("R5 write 38 err", err, 0);
        bus_rd(8'h20, d, e); chk("R5 write 38 no effect", d, 32'h8);

        // R10 unmapped accesses
        bus_rd(8'h30, d, e); chk("R10 unmapped read data", d, 0); chk("R10 unmapped read err", e, 1);
        @(negedge clk);
        chk("R10 err one cycle", err, 0);
        bus_wr(8'h30, 32'hFFFF_FFFF);
        chk("R10 unmapped write err", err, 1);
        bus_wr(8'h20, 32'h0000_0008);
        chk("R10 read-only write err", err, 1);
        bus_rd(8'h20, d, e); chk("R10 read-only write no effect", d, 32'h8);
        chk("R10 mapped read no err", e, 0);
        bus_rd(8'h28, d, e); chk("R10 ack read data", d, 0); chk("R10 ack read err", e, 1);
        bus_rd(8'h24, d, e); chk("R10 enables untouched", d, 0);
        bus_rd(8'h14, d, e); chk("R10 enables high untouched", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule